// File: doc/BRIEF.md
# Split Instruction/Data Cache Request Router

This block sits between a processor's request queue and the coherence controller of a private cache pair that is split into an instruction side and a data side. Each processor request arrives with a type code and a line address. The tag lookups of both caches are presented to the router as inputs: a presence bit per cache, a free-way bit per cache, and a victim line address per cache. From these the router picks exactly one event per decision and hands it to the controller through a valid/ready pair. The event is a load, an instruction fetch, a store, or a replacement aimed at one of the two caches.

The router keeps the two caches exclusive. A line that is wanted in one cache but found in the other is evicted from the other cache first. A line that misses both caches while its target set is full causes the supplied victim to be evicted first. Replacement events leave the processor request pending. Once the controller accepts an event, the router waits one idle cycle. It then decides again from lookups that already reflect the eviction. The request is consumed only when its final, non-replacement event is accepted. While the coherence side signals traffic of its own, the router starts nothing new, so network messages keep precedence. Unknown type codes and a line present in both caches are flagged and dropped.

Top module: `split_req_router`

## Requirements
- R1: Type code 1 (instruction fetch) is routed to the instruction cache. Codes 0 (load), 2 (store) and 3 (atomic) are routed to the data cache. `evtIcache` is 1 when an event targets the instruction cache and 0 when it targets the data cache.
- R2: Event codes on `evtKind` are 0 load, 1 instruction fetch, 2 store and 3 replacement. Store and atomic requests both produce event code 2.
- R3: When the routed-to cache holds the line, the request's own event is issued on that cache with the request line. Accepting it consumes the request (`reqReady` high in the accepting cycle).
- R4: When the routed-to cache misses and the opposite cache holds the line, a replacement event is issued on the opposite cache with the request line.
- R5: When both caches miss and the routed-to cache has a free way, the request's own event is issued on that cache with the request line.
- R6: When both caches miss and the routed-to cache has no free way, a replacement event is issued on that cache with that cache's victim line.
- R7: Accepting a replacement event does not consume the request: `reqReady` stays low.
- R8: A type code of 4 to 7 raises `errType` and consumes the request in the same cycle, and no event is issued.
- R9: A valid type with the line present in both caches raises `errDual` and consumes the request, and no event is issued.
- R10: While `netBusy` is high, no new event is started and no request is consumed.
- R11: An issued event keeps its code, target cache and line unchanged until it is accepted, whatever the lookup inputs do meanwhile.
- R12: After reset and in the cycle following any accepted event, `evtValid` is low. The next decision therefore uses fresh lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Request consumed this cycle |
| reqType | input | 3 | Request type code (see R1, R8) |
| reqLine | input | LINE_W | Request line address |
| iPresent | input | 1 | Instruction cache holds the request line |
| dPresent | input | 1 | Data cache holds the request line |
| iFree | input | 1 | Instruction cache set has a free way |
| dFree | input | 1 | Data cache set has a free way |
| iVictim | input | LINE_W | Instruction cache victim line for the request's set |
| dVictim | input | LINE_W | Data cache victim line for the request's set |
| netBusy | input | 1 | Coherence-side messages are being served |
| evtValid | output | 1 | Event present |
| evtReady | input | 1 | Controller accepts the event |
| evtKind | output | 2 | Event code (see R2) |
| evtIcache | output | 1 | Event targets the instruction cache |
| evtLine | output | LINE_W | Event line address |
| errType | output | 1 | Unknown type code dropped this cycle |
| errDual | output | 1 | Line found in both caches, request dropped |

## Verification
The bound checker checks every cycle that an event holds stable until it is accepted, and that every accept is followed by an idle cycle. It also checks that `netBusy` blocks new events, that replacements never consume the request while final events always do, that error drops carry no event, and that fetch and data events land on the right cache side. Only the bench's scenarios can show that the chosen event and line match the lookup pattern for each routing case and for the victim selection. The same holds for store and atomic collapsing to one code, and for the wrong-cache eviction followed by a fresh decision that completes the request.

// File: rtl/split_req_router_pkg.sv
package split_req_router_pkg;

  typedef enum logic [1:0] {
    EV_LOAD   = 2'd0,
    EV_IFETCH = 2'd1,
    EV_STORE  = 2'd2,
    EV_REPL   = 2'd3
  } evtKind_e;

  localparam logic [2:0] RQ_LOAD   = 3'd0;
  localparam logic [2:0] RQ_IFETCH = 3'd1;
  localparam logic [2:0] RQ_STORE  = 3'd2;
  localparam logic [2:0] RQ_ATOMIC = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;       // capture a new event this cycle
    logic     isRepl;     // event is a replacement
    logic     targetI;    // event aims at the instruction cache
    logic     useVictim;  // line comes from the target cache's victim
    evtKind_e kind;       // request's own event code
  } ctlStrobe_t;

endpackage

// File: rtl/req_decode.sv
module req_decode
  import split_req_router_pkg::*;
(
  input  logic [2:0] reqType,
  output logic       typeOk,
  output logic       wantIcache,
  output evtKind_e   baseKind
);
  always_comb begin
    typeOk     = 1'b1;
    wantIcache = 1'b0;
    baseKind   = EV_LOAD;
    case (reqType)
      RQ_LOAD:   baseKind = EV_LOAD;
      RQ_IFETCH: begin
        wantIcache = 1'b1;
        baseKind   = EV_IFETCH;
      end
      RQ_STORE, RQ_ATOMIC: baseKind = EV_STORE;
      default:   typeOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import split_req_router_pkg::*;
(
  input  logic       reqValid,
  input  logic       netBusy,
  input  logic       typeOk,
  input  logic       wantIcache,
  input  evtKind_e   baseKind,
  input  logic       iPresent,
  input  logic       dPresent,
  input  logic       iFree,
  input  logic       dFree,
  input  logic       evtValid,
  input  logic       evtReady,
  input  logic       heldRepl,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       errType,
  output logic       errDual
);
  logic eligible;
  logic dual;
  logic rightHit;
  logic wrongHit;
  logic rightFree;
  logic finalAccept;

  always_comb begin
    eligible  = reqValid && !netBusy && !evtValid;
    dual      = iPresent && dPresent;
    rightHit  = wantIcache ? iPresent : dPresent;
    wrongHit  = wantIcache ? dPresent : iPresent;
    rightFree = wantIcache ? iFree    : dFree;

    errType = eligible && !typeOk;
    errDual = eligible && typeOk && dual;

    strobe.load      = eligible && typeOk && !dual;
    strobe.isRepl    = !rightHit && (wrongHit || !rightFree);
    strobe.targetI   = (!rightHit && wrongHit) ? !wantIcache : wantIcache;
    strobe.useVictim = !rightHit && !wrongHit && !rightFree;
    strobe.kind      = baseKind;

    finalAccept = evtValid && evtReady && !heldRepl;
    reqReady    = finalAccept || errType || errDual;
  end
endmodule

// File: rtl/router_datapath.sv
module router_datapath
  import split_req_router_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [LINE_W-1:0] iVictim,
  input  logic [LINE_W-1:0] dVictim,
  input  logic              evtReady,
  output logic              evtValid,
  output logic [1:0]        evtKind,
  output logic              evtIcache,
  output logic [LINE_W-1:0] evtLine,
  output logic              heldRepl
);
  logic [LINE_W-1:0] victimLine;
  logic [LINE_W-1:0] nextLine;
  evtKind_e          nextKind;

  always_comb begin
    victimLine = strobe.targetI ? iVictim : dVictim;
    nextLine   = strobe.useVictim ? victimLine : reqLine;
    nextKind   = strobe.isRepl ? EV_REPL : strobe.kind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid  <= 1'b0;
      evtKind   <= EV_LOAD;
      evtIcache <= 1'b0;
      evtLine   <= '0;
    end else if (strobe.load) begin
      evtValid  <= 1'b1;
      evtKind   <= nextKind;
      evtIcache <= strobe.targetI;
      evtLine   <= nextLine;
    end else if (evtValid && evtReady) begin
      evtValid <= 1'b0;
    end
  end

  assign heldRepl = (evtKind == EV_REPL);
endmodule

// File: rtl/split_req_router.sv
module split_req_router
  import split_req_router_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqType,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              iPresent,
  input  logic              dPresent,
  input  logic              iFree,
  input  logic              dFree,
  input  logic [LINE_W-1:0] iVictim,
  input  logic [LINE_W-1:0] dVictim,
  input  logic              netBusy,
  output logic              evtValid,
  input  logic              evtReady,
  output logic [1:0]        evtKind,
  output logic              evtIcache,
  output logic [LINE_W-1:0] evtLine,
  output logic              errType,
  output logic              errDual
);
  logic       typeOk;
  logic       wantIcache;
  evtKind_e   baseKind;
  ctlStrobe_t strobe;
  logic       heldRepl;

  req_decode u_decode (
    .reqType   (reqType),
    .typeOk    (typeOk),
    .wantIcache(wantIcache),
    .baseKind  (baseKind)
  );

  router_ctrl u_ctrl (
    .reqValid  (reqValid),
    .netBusy   (netBusy),
    .typeOk    (typeOk),
    .wantIcache(wantIcache),
    .baseKind  (baseKind),
    .iPresent  (iPresent),
    .dPresent  (dPresent),
    .iFree     (iFree),
    .dFree     (dFree),
    .evtValid  (evtValid),
    .evtReady  (evtReady),
    .heldRepl  (heldRepl),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .errType   (errType),
    .errDual   (errDual)
  );

  router_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqLine  (reqLine),
    .iVictim  (iVictim),
    .dVictim  (dVictim),
    .evtReady (evtReady),
    .evtValid (evtValid),
    .evtKind  (evtKind),
    .evtIcache(evtIcache),
    .evtLine  (evtLine),
    .heldRepl (heldRepl)
  );
endmodule

// File: rtl/split_req_router_chk.sv
module split_req_router_chk #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              netBusy,
  input logic              evtValid,
  input logic              evtReady,
  input logic [1:0]        evtKind,
  input logic              evtIcache,
  input logic [LINE_W-1:0] evtLine,
  input logic              errType,
  input logic              errDual
);
  AST_NET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!evtValid && netBusy) |=> !evtValid) else $error("net priority"); // R10
  AST_NET_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (!evtValid && netBusy) |-> !reqReady) else $error("net pop"); // R10
  AST_HOLD_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady) |=> (evtValid && $stable(evtKind) && $stable(evtIcache) && $stable(evtLine)))
    else $error("event changed"); // R11
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtReady) |=> !evtValid) else $error("no idle cycle"); // R12
  AST_REPL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == 2'd3) |-> !reqReady) else $error("replacement popped"); // R7
  AST_FINAL_POPS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtReady && evtKind != 2'd3) |-> reqReady) else $error("final not popped"); // R3
  AST_FETCH_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == 2'd1) |-> evtIcache) else $error("fetch side"); // R1
  AST_DATA_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && (evtKind == 2'd0 || evtKind == 2'd2)) |-> !evtIcache) else $error("data side"); // R1
  AST_TYPE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    errType |-> (reqReady && !evtValid && reqValid)) else $error("type drop"); // R8
  AST_DUAL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    errDual |-> (reqReady && !evtValid && !errType)) else $error("dual drop"); // R9
endmodule

bind split_req_router split_req_router_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .netBusy(netBusy), .evtValid(evtValid), .evtReady(evtReady),
  .evtKind(evtKind), .evtIcache(evtIcache), .evtLine(evtLine),
  .errType(errType), .errDual(errDual)
);

// File: tb/split_req_router_bench.sv
module split_req_router_bench;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqType = '0;
  logic [LW-1:0] reqLine = '0;
  logic          iPresent = 1'b0, dPresent = 1'b0, iFree = 1'b0, dFree = 1'b0;
  logic [LW-1:0] iVictim = '0, dVictim = '0;
  logic          netBusy = 1'b0;
  logic          evtValid;
  logic          evtReady = 1'b0;
  logic [1:0]    evtKind;
  logic          evtIcache;
  logic [LW-1:0] evtLine;
  logic          errType, errDual;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  split_req_router #(.LINE_W(LW)) u_split_req_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqLine(reqLine), .iPresent(iPresent), .dPresent(dPresent),
    .iFree(iFree), .dFree(dFree), .iVictim(iVictim), .dVictim(dVictim),
    .netBusy(netBusy), .evtValid(evtValid), .evtReady(evtReady), .evtKind(evtKind),
    .evtIcache(evtIcache), .evtLine(evtLine), .errType(errType), .errDual(errDual)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outcome from the requirements; errKind 0 none, 1 type, 2 dual
  task automatic predict(input logic [2:0] t, input logic ip, dp, ifr, dfr,
                         input logic [LW-1:0] ln, iv, dv,
                         output int errKind, output logic [1:0] k, output logic ic,
                         output logic [LW-1:0] el, output string tag);
    logic wantI, rh, wh, rf;
    errKind = 0; k = 2'd0; ic = 1'b0; el = ln; tag = "R3";
    if (t > 3'd3) begin errKind = 1; tag = "R8"; return; end
    if (ip && dp) begin errKind = 2; tag = "R9"; return; end
    wantI = (t == 3'd1);
    rh = wantI ? ip : dp;
    wh = wantI ? dp : ip;
    rf = wantI ? ifr : dfr;
    k  = (t == 3'd0) ? 2'd0 : (t == 3'd1) ? 2'd1 : 2'd2;
    ic = wantI;
    if (rh) tag = "R3";
    else if (wh) begin k = 2'd3; ic = !wantI; tag = "R4"; end
    else if (rf) tag = "R5";
    else begin k = 2'd3; el = wantI ? iv : dv; tag = "R6"; end
  endtask

  task automatic runVec(input logic [2:0] t, input logic ip, dp, ifr, dfr,
                        input logic [LW-1:0] ln, iv, dv, input int stall);
    int errKind; logic [1:0] k; logic ic; logic [LW-1:0] el; string tag;
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqLine = ln;
    iPresent = ip; dPresent = dp; iFree = ifr; dFree = dfr;
    iVictim = iv; dVictim = dv; evtReady = 1'b0; netBusy = 1'b0;
    predict(t, ip, dp, ifr, dfr, ln, iv, dv, errKind, k, ic, el, tag);
    #1;
    if (errKind != 0) begin
      chk(reqReady == 1'b1, tag, reqReady, 1);
      chk(errType == (errKind == 1), "R8", errType, errKind == 1);
      chk(errDual == (errKind == 2), "R9", errDual, errKind == 2);
      @(negedge clk);
      reqValid = 1'b0;
      chk(evtValid == 1'b0, tag, evtValid, 0);
    end else begin
      chk(reqReady == 1'b0, tag, reqReady, 0);
      @(negedge clk);
      chk(evtValid == 1'b1, tag, evtValid, 1);
      chk(evtKind == k, (t == 3'd2 || t == 3'd3) ? "R2" : tag, evtKind, k);
      chk(evtIcache == ic, "R1", evtIcache, ic);
      chk(evtLine == el, tag, evtLine, el);
      for (int s = 0; s < stall; s++) begin
        iPresent = $urandom; dPresent = $urandom; iVictim = $urandom; dVictim = $urandom;
        @(negedge clk);
        chk(evtValid && evtKind == k && evtIcache == ic && evtLine == el, "R11",
            {evtKind, evtIcache, evtLine}, {k, ic, el});
      end
      evtReady = 1'b1;
      #1;
      chk(reqReady == (k != 2'd3), (k == 2'd3) ? "R7" : "R3", reqReady, k != 2'd3);
      @(negedge clk);
      evtReady = 1'b0; reqValid = 1'b0;
      chk(evtValid == 1'b0, "R12", evtValid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    chk(evtValid == 1'b0, "R12", evtValid, 0);
    chk(reqReady == 1'b0, "R12", reqReady, 0);
    rstN = 1'b1;

    // directed: each routing case
    runVec(3'd1, 1, 0, 0, 0, 26'h00abc, 26'h1, 26'h2, 0); // R3 fetch hit
    runVec(3'd0, 1, 0, 0, 1, 26'h00123, 26'h3, 26'h4, 1); // R4 load held in I
    runVec(3'd3, 0, 0, 0, 1, 26'h00777, 26'h5, 26'h6, 0); // R5 atomic alloc, R2
    runVec(3'd2, 0, 0, 1, 0, 26'h00999, 26'h7, 26'h8, 2); // R6 store victim
    runVec(3'd1, 0, 0, 0, 0, 26'h00555, 26'h9, 26'ha, 0); // R6 fetch victim
    runVec(3'd6, 0, 0, 0, 0, 26'h00111, 26'h0, 26'h0, 0); // R8
    runVec(3'd0, 1, 1, 0, 0, 26'h00222, 26'h0, 26'h0, 0); // R9

    // directed: R10 network priority
    @(negedge clk);
    reqValid = 1'b1; reqType = 3'd0; reqLine = 26'h0444;
    iPresent = 0; dPresent = 1; netBusy = 1'b1; evtReady = 1'b0;
    #1 chk(reqReady == 1'b0, "R10", reqReady, 0);
    @(negedge clk); chk(evtValid == 1'b0, "R10", evtValid, 0);
    @(negedge clk); chk(evtValid == 1'b0, "R10", evtValid, 0);
    netBusy = 1'b0;
    @(negedge clk); chk(evtValid == 1'b1 && evtKind == 2'd0, "R10", evtValid, 1);
    evtReady = 1'b1;
    @(negedge clk); evtReady = 1'b0; reqValid = 1'b0;

    // directed: R4 eviction then fresh decision completes the request (R7, R12)
    @(negedge clk);
    reqValid = 1'b1; reqType = 3'd2; reqLine = 26'h0321;
    iPresent = 1; dPresent = 0; dFree = 0; iFree = 0;
    @(negedge clk);
    chk(evtKind == 2'd3 && evtIcache == 1'b1 && evtLine == 26'h0321, "R4", {evtKind, evtIcache}, 7);
    evtReady = 1'b1;
    #1 chk(reqReady == 1'b0, "R7", reqReady, 0);
    @(negedge clk);
    evtReady = 1'b0; iPresent = 0; dFree = 1;
    chk(evtValid == 1'b0, "R12", evtValid, 0);
    @(negedge clk);
    chk(evtValid && evtKind == 2'd2 && !evtIcache && evtLine == 26'h0321, "R5", {evtKind, evtIcache}, 4);
    evtReady = 1'b1;
    #1 chk(reqReady == 1'b1, "R3", reqReady, 1);
    @(negedge clk); evtReady = 1'b0; reqValid = 1'b0;

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] t; logic ip, dp;
      t  = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      ip = $urandom; dp = $urandom;
      if (ip && dp && ($urandom % 4 != 0)) dp = 1'b0;
      runVec(t, ip, dp, 1'($urandom), 1'($urandom), LW'($urandom), LW'($urandom),
             LW'($urandom), int'($urandom % 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule